// File: doc/BRIEF.md
# Pipelined Carry-Save Array Multiplier

This block multiplies two unsigned operands in a fully pipelined array of carry-save rows. Each multiplier bit drives one row, which adds the gated multiplicand into a redundant sum/carry pair. With the default sizing of 32-bit operands, each row counts as two gate delays. A pipeline register follows every four rows, so no more than eight gate delays lie between registers. This gives eight array stages. A ninth stage is a carry-propagate adder that turns the redundant pair into the upper half of the 64-bit product.

Every array stage register holds the running sum and carry vectors and the product bits already settled. It also holds the multiplier bits not yet consumed and the multiplicand that later rows still need. A valid flag moves with each operation. A new operand pair may be issued on every clock. Products appear in issue order, exactly nine cycles later. A synchronous reset clears only the valid flags.

Top module: `csa_pipe_multiplier`

## Requirements
- R1: When `out_valid` is high, `out_product` equals the unsigned 64-bit product of the `in_a` and `in_b` values that were issued nine cycles earlier.
- R2: An operand pair sampled with `in_valid` high at a rising edge produces `out_valid` high after exactly nine rising edges, not earlier and not later.
- R3: Operand pairs issued on consecutive cycles are all accepted, and their products come out on consecutive cycles in issue order.
- R4: A cycle with `in_valid` low produces a cycle with `out_valid` low nine cycles later, so gaps in the input stream are kept at the output.
- R5: While `rst` is high at a rising edge, every valid flag is cleared at that edge. Operations in flight and any pair offered during reset never produce `out_valid`. `out_valid` is low after reset.
- R6: Boundary operands give exact products:
  - zero times any value gives 0;
  - all-ones times all-ones gives 0xFFFFFFFE00000001;
  - one times X gives X;
  - 0x80000000 squared gives 0x4000000000000000.
- R7: For every valid operation, the sum of the final sum and carry vectors fits in 32 bits. The final adder therefore never produces a carry out of the product.

Operand width and the number of rows per stage are parameters. The latency is the operand width divided by the rows per stage, plus one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous reset, clears all valid flags |
| in_valid | input | 1 | Operand pair on `in_a`/`in_b` is to be multiplied |
| in_a | input | 32 | Multiplicand, unsigned |
| in_b | input | 32 | Multiplier, unsigned; bit i drives row i |
| out_valid | output | 1 | `out_product` holds a finished result |
| out_product | output | 64 | Unsigned product |

## Verification
Every result is due exactly nine rising edges after its operand pair is sampled. The bench keeps a 16-entry history of what it issued on each cycle. On every cycle it compares the output sampled at the falling edge with the entry issued nine cycles earlier. The valid flag and the product must both match, so an output one cycle early or late fails.

When reset is applied, the bench marks the nine most recent history entries as cleared. This includes the pair offered in the reset cycle, and those slots must then show `out_valid` low.

// File: rtl/csa_pipe_pkg.sv
package csa_pipe_pkg;
    // Default sizing: operand width and carry-save rows between registers.
    localparam int DEF_WIDTH          = 32;
    localparam int DEF_ROWS_PER_STAGE = 4;
    // Gate-delay budget per row (two-level logic) and per register slice.
    localparam int ROW_GATE_DELAYS    = 2;
    localparam int MAX_GATE_DELAYS    = 8;
endpackage

// File: rtl/csa_row_stage.sv
module csa_row_stage #(
    parameter int WIDTH = csa_pipe_pkg::DEF_WIDTH,
    parameter int ROWS  = csa_pipe_pkg::DEF_ROWS_PER_STAGE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             valid_i,
    input  logic [WIDTH-1:0] mcand_i,
    input  logic [WIDTH-1:0] mplier_i,
    input  logic [WIDTH-1:0] psum_i,
    input  logic [WIDTH-1:0] pcarry_i,
    input  logic [WIDTH-1:0] low_i,
    output logic             valid_o,
    output logic [WIDTH-1:0] mcand_o,
    output logic [WIDTH-1:0] mplier_o,
    output logic [WIDTH-1:0] psum_o,
    output logic [WIDTH-1:0] pcarry_o,
    output logic [WIDTH-1:0] low_o
);
    typedef struct packed {
        logic             valid;
        logic [WIDTH-1:0] mcand;
        logic [WIDTH-1:0] mplier;
        logic [WIDTH-1:0] psum;
        logic [WIDTH-1:0] pcarry;
        logic [WIDTH-1:0] low;
    } slice_t;

    slice_t slice_d, slice_q;

    // ROWS carry-save rows; each row retires one settled product bit.
    always_comb begin
        logic [WIDTH-1:0] pp;
        logic [WIDTH-1:0] rsum;
        logic [WIDTH-1:0] rcy;
        slice_d.valid  = valid_i;
        slice_d.mcand  = mcand_i;
        slice_d.mplier = mplier_i;
        slice_d.psum   = psum_i;
        slice_d.pcarry = pcarry_i;
        slice_d.low    = low_i;
        for (int r = 0; r < ROWS; r++) begin
            pp   = slice_d.mcand & {WIDTH{slice_d.mplier[0]}};
            rsum = slice_d.psum ^ slice_d.pcarry ^ pp;
            rcy  = (slice_d.psum & slice_d.pcarry) | (slice_d.psum & pp)
                 | (slice_d.pcarry & pp);
            slice_d.low    = {rsum[0], slice_d.low[WIDTH-1:1]};
            slice_d.psum   = rsum >> 1;
            slice_d.pcarry = rcy;
            slice_d.mplier = slice_d.mplier >> 1;
        end
    end

    always_ff @(posedge clk) begin
        slice_q <= slice_d;
        if (rst) begin
            slice_q.valid <= 1'b0;
        end
    end

    assign valid_o  = slice_q.valid;
    assign mcand_o  = slice_q.mcand;
    assign mplier_o = slice_q.mplier;
    assign psum_o   = slice_q.psum;
    assign pcarry_o = slice_q.pcarry;
    assign low_o    = slice_q.low;

    // R2 / R3: a live operation always moves one slice per clock.
    a_r2_valid_advances: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    // R4: a bubble stays a bubble.
    a_r4_bubble_advances: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
    // R5: reset empties this slice.
    a_r5_reset_clears: assert property (@(posedge clk)
        rst |=> !valid_o);
endmodule

// File: rtl/csa_final_adder.sv
module csa_final_adder #(
    parameter int WIDTH = csa_pipe_pkg::DEF_WIDTH
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               valid_i,
    input  logic [WIDTH-1:0]   psum_i,
    input  logic [WIDTH-1:0]   pcarry_i,
    input  logic [WIDTH-1:0]   low_i,
    output logic               valid_o,
    output logic [2*WIDTH-1:0] product_o
);
    typedef struct packed {
        logic               valid;
        logic [2*WIDTH-1:0] product;
    } result_t;

    result_t res_d, res_q;
    logic    carry_out;
    logic [WIDTH-1:0] high_sum;

    always_comb begin
        {carry_out, high_sum} = {1'b0, psum_i} + {1'b0, pcarry_i};
        res_d.valid   = valid_i;
        res_d.product = {high_sum, low_i};
    end

    always_ff @(posedge clk) begin
        res_q <= res_d;
        if (rst) begin
            res_q.valid <= 1'b0;
        end
    end

    assign valid_o   = res_q.valid;
    assign product_o = res_q.product;

    // R7: the redundant upper half of a real product never overflows.
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (rst)
        valid_i |-> !carry_out);
    a_r2_result_follows: assert property (@(posedge clk) disable iff (rst)
        valid_i |=> valid_o);
    a_r4_bubble_follows: assert property (@(posedge clk) disable iff (rst)
        !valid_i |=> !valid_o);
endmodule

// File: rtl/csa_pipe_multiplier.sv
module csa_pipe_multiplier #(
    parameter int WIDTH          = csa_pipe_pkg::DEF_WIDTH,
    parameter int ROWS_PER_STAGE = csa_pipe_pkg::DEF_ROWS_PER_STAGE
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [WIDTH-1:0]   in_a,
    input  logic [WIDTH-1:0]   in_b,
    output logic               out_valid,
    output logic [2*WIDTH-1:0] out_product
);
    localparam int ARRAY_STAGES = WIDTH / ROWS_PER_STAGE;
    localparam int LATENCY      = ARRAY_STAGES + 1;

    logic             vld [0:ARRAY_STAGES];
    logic [WIDTH-1:0] mca [0:ARRAY_STAGES];
    logic [WIDTH-1:0] mpl [0:ARRAY_STAGES];
    logic [WIDTH-1:0] ps  [0:ARRAY_STAGES];
    logic [WIDTH-1:0] pc  [0:ARRAY_STAGES];
    logic [WIDTH-1:0] lo  [0:ARRAY_STAGES];

    // Array entry: empty redundant pair, nothing settled yet.
    assign vld[0] = in_valid;
    assign mca[0] = in_a;
    assign mpl[0] = in_b;
    assign ps[0]  = '0;
    assign pc[0]  = '0;
    assign lo[0]  = '0;

    for (genvar g = 0; g < ARRAY_STAGES; g++) begin : g_slice
        csa_row_stage #(
            .WIDTH (WIDTH),
            .ROWS  (ROWS_PER_STAGE)
        ) i_slice (
            .clk      (clk),
            .rst      (rst),
            .valid_i  (vld[g]),
            .mcand_i  (mca[g]),
            .mplier_i (mpl[g]),
            .psum_i   (ps[g]),
            .pcarry_i (pc[g]),
            .low_i    (lo[g]),
            .valid_o  (vld[g+1]),
            .mcand_o  (mca[g+1]),
            .mplier_o (mpl[g+1]),
            .psum_o   (ps[g+1]),
            .pcarry_o (pc[g+1]),
            .low_o    (lo[g+1])
        );
    end

    csa_final_adder #(
        .WIDTH (WIDTH)
    ) i_final (
        .clk       (clk),
        .rst       (rst),
        .valid_i   (vld[ARRAY_STAGES]),
        .psum_i    (ps[ARRAY_STAGES]),
        .pcarry_i  (pc[ARRAY_STAGES]),
        .low_i     (lo[ARRAY_STAGES]),
        .valid_o   (out_valid),
        .product_o (out_product)
    );

    initial begin
        a_r2_stage_split: assert (ARRAY_STAGES * ROWS_PER_STAGE == WIDTH
            && LATENCY == ARRAY_STAGES + 1
            && ROWS_PER_STAGE * csa_pipe_pkg::ROW_GATE_DELAYS
               <= csa_pipe_pkg::MAX_GATE_DELAYS);
    end

    // R1: a delivered product is always fully defined.
    a_r1_product_known: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> !$isunknown(out_product));
endmodule

// File: tb/test_csa_pipe_multiplier.sv
module test_csa_pipe_multiplier;
    localparam int CLK_PERIOD = 10;
    localparam int LAT        = 9;
    localparam int HIST       = 16;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [31:0] in_a = '0;
    logic [31:0] in_b = '0;
    logic        out_valid;
    logic [63:0] out_product;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit done   = 1'b0;

    logic        h_v [HIST];
    logic [63:0] h_p [HIST];
    string       h_t [HIST];

    always #(CLK_PERIOD/2) clk = ~clk;

    csa_pipe_multiplier i_csa_pipe_multiplier (
        .clk         (clk),
        .rst         (rst),
        .in_valid    (in_valid),
        .in_a        (in_a),
        .in_b        (in_b),
        .out_valid   (out_valid),
        .out_product (out_product)
    );

    function automatic logic [63:0] ref_mul(input logic [31:0] a, input logic [31:0] b);
        return {32'd0, a} * {32'd0, b};
    endfunction

    task automatic report(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s cycle %0d: actual=%h expected=%h", tag, cyc, act, exp);
        end
    endtask

    // One clock: check the slot issued LAT cycles ago, then drive the next inputs.
    task automatic step(input logic v, input logic [31:0] a, input logic [31:0] b,
                        input string tag, input logic r);
        int slot;
        @(negedge clk);
        if (cyc > 0) begin
            slot = (cyc - LAT + HIST) % HIST;
            report(h_t[slot], {63'd0, out_valid}, {63'd0, h_v[slot]});
            if (h_v[slot]) report(h_t[slot], out_product, h_p[slot]);
        end
        rst      = r;
        in_valid = v;
        in_a     = a;
        in_b     = b;
        slot = cyc % HIST;
        h_v[slot] = v;
        h_p[slot] = ref_mul(a, b);
        h_t[slot] = v ? tag : "R4";
        if (r) begin
            for (int d = 0; d < LAT; d++) begin
                h_v[(cyc - d + HIST) % HIST] = 1'b0;
                h_t[(cyc - d + HIST) % HIST] = "R5";
            end
        end
        cyc++;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, '0, '0, "R4", 1'b0);
    endtask

    initial begin
        for (int i = 0; i < HIST; i++) begin
            h_v[i] = 1'b0;
            h_p[i] = '0;
            h_t[i] = "R5";
        end
        void'($urandom(32'd1234));
        // R5: pairs offered during reset are dropped
        for (int i = 0; i < 3; i++) step(1'b1, 32'd7, 32'd9, "R5", 1'b1);
        @(negedge clk);
        report("R5", {63'd0, out_valid}, 64'd0);
        // R6 corners, issued back to back
        step(1'b1, 32'd0, 32'hFFFF_FFFF, "R6", 1'b0);
        step(1'b1, 32'hFFFF_FFFF, 32'hFFFF_FFFF, "R6", 1'b0);
        step(1'b1, 32'd1, 32'hDEAD_BEEF, "R6", 1'b0);
        step(1'b1, 32'h1234_5678, 32'd1, "R6", 1'b0);
        step(1'b1, 32'h8000_0000, 32'h8000_0000, "R6", 1'b0);
        step(1'b1, 32'hFFFF_FFFF, 32'd0, "R6", 1'b0);
        idle(12);
        // R2: isolated operation, exact latency
        step(1'b1, 32'hCAFE_0001, 32'h0000_0F0F, "R2", 1'b0);
        idle(12);
        // R3: back-to-back random stream
        for (int i = 0; i < 150; i++) step(1'b1, $urandom, $urandom, "R3", 1'b0);
        // R1 / R4: random stream with bubbles
        for (int i = 0; i < 150; i++) step(1'($urandom % 2), $urandom, $urandom, "R1", 1'b0);
        idle(12);
        // R5: reset with operations in flight
        for (int i = 0; i < 5; i++) step(1'b1, $urandom, $urandom, "R5", 1'b0);
        step(1'b1, $urandom, $urandom, "R5", 1'b1);
        step(1'b1, $urandom, $urandom, "R5", 1'b1);
        idle(12);
        for (int i = 0; i < 5; i++) step(1'b1, $urandom, $urandom, "R1", 1'b0);
        idle(12);
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule